// File: doc/BRIEF.md
# Two-Wire Register Slave with Stored Pointer

This block is a two-wire (I2C fast-mode) slave that lets a bus master program a small bank of control registers. A system clock oversamples both bus lines through a synchronizer and a glitch filter, and the slave drives the data line only as an open-drain pull-down. It never drives the clock line. Two three-level strap inputs choose the bus address, so up to nine slaves can share one bus.

The first byte after the address in a write is a command byte, and it loads an internal pointer. Every data byte after it goes out on a generic register write port at the pointer, and then the pointer advances. A read returns the byte at the stored pointer. The pointer does not move between read bytes, so a burst read keeps sampling one register. The register file outside the block decides what each address holds. When the alternate serial control path is selected, the slave goes quiet.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset the data-line pull-down (`sda_oe`) is released and `reg_we` is low.
- R2: Each strap is coded 2'b00 = low (0), 2'b01 = open (1), 2'b10 or 2'b11 = high (2). The 7-bit address is 0x50 + 3*level(strap_a) + level(strap_b), followed by the R/W bit as LSB. Only a matching address is acknowledged. After a mismatch, the rest of the transaction draws no acknowledge and no write.
- R3: The first byte after a write address is acknowledged and loaded into the pointer. A STOP right after it causes no register write.
- R4: Each later data byte is acknowledged and presented once, as a single-cycle `reg_we` with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte (MSB received first).
- R5: After each data byte the pointer advances by one, wrapping from 0xFF to 0x00.
- R6: After an address with R/W = 1, the slave shifts out the byte at the pointer, MSB first. Every byte the master acknowledges is followed by the same register again, because the pointer does not advance on reads.
- R7: After the master NACKs a read byte, the slave releases the data line and does not drive it again in that transaction.
- R8: A repeated START at any point restarts the address phase, and the pointer keeps its value.
- R9: A pulse on SCL shorter than FILT_LEN system clocks (default 3) has no effect on the received data.
- R10: While `alt_ctl_sel` is high, the slave does not acknowledge, does not write and leaves the data line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls the data line low |
| strap_a | input | 2 | First three-level address strap |
| strap_b | input | 2 | Second three-level address strap |
| alt_ctl_sel | input | 1 | High selects the alternate control path and disables this slave |
| reg_addr | output | 8 | Register address (the pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_rdata | input | 8 | Register read data at reg_addr |

## Verification
The write strobe and the pointer advance happen on the same clock edge. If the two were skewed, the strobe would carry a pointer that was already incremented. The bench provokes this with two-byte bursts, including one that starts at 0xFF. It judges the result by the write addresses it sees on the write port, and then by a repeated-START read that must return the register one past the last write target, which shows which pointer value survived.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } slv_state_e;

  localparam logic [6:0] ADDR_BASE = 7'h50;

  // three-level strap code to numeric level
  function automatic logic [1:0] strap_level(input logic [1:0] code);
    logic [1:0] lvl;
    case (code)
      2'b00:   lvl = 2'd0;
      2'b01:   lvl = 2'd1;
      default: lvl = 2'd2;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/i2c_rs_deglitch.sv
module i2c_rs_deglitch #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic          out_q, out_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    out_d = out_q;
    cnt_d = '0;
    if (sync_q[1] != out_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) out_d = sync_q[1];
      else                            cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      out_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], din};
      out_q  <= out_d;
      cnt_q  <= cnt_d;
    end
  end

  assign dout = out_q;

  // R9: filtered level only moves after the synchronized input held it
  p_filter_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> ($past(sync_q[1]) == out_q));

endmodule

// File: rtl/i2c_rs_busev.sv
module i2c_rs_busev (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;

endmodule

// File: rtl/i2c_rs_engine.sv
module i2c_rs_engine
  import i2c_rs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [6:0] my_addr,
  input  logic       scl_lvl,
  input  logic       sda_in,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] reg_rdata,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we
);
  slv_state_e state_q, state_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] ptr_q, ptr_d;
  logic [3:0] cnt_q, cnt_d;
  logic       rw_q, rw_d;
  logic       nack_q, nack_d;
  logic       we;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    cnt_d   = cnt_q;
    rw_d    = rw_q;
    nack_d  = nack_q;
    we      = 1'b0;
    if (!en) begin
      state_d = ST_IDLE;
    end else if (start_ev) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
    end else if (stop_ev) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_ADDR, ST_CMD, ST_WR: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_d  = {sh_q[6:0], sda_in};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == my_addr) begin
                rw_d    = sh_q[0];
                state_d = ST_ADDR_ACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_CMD) begin
              ptr_d   = sh_q;
              state_d = ST_CMD_ACK;
            end else begin
              we      = 1'b1;
              ptr_d   = ptr_q + 8'd1;
              state_d = ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              state_d = ST_RD;
              sh_d    = reg_rdata;
            end else begin
              state_d = ST_CMD;
            end
          end
        end
        ST_CMD_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            cnt_d   = '0;
            state_d = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              state_d = ST_RD_ACK;
              cnt_d   = '0;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            nack_d = sda_in;
          end else if (scl_fall) begin
            if (nack_q) begin
              state_d = ST_IDLE;
            end else begin
              state_d = ST_RD;
              sh_d    = reg_rdata;
              cnt_d   = '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      cnt_q   <= cnt_d;
      rw_q    <= rw_d;
      nack_q  <= nack_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_ADDR_ACK, ST_CMD_ACK, ST_WR_ACK: sda_oe = en;
      ST_RD:                              sda_oe = en & ~sh_q[7];
      default:                            sda_oe = 1'b0;
    endcase
  end

  assign reg_addr  = ptr_q;
  assign reg_wdata = sh_q;
  assign reg_we    = we;

  // R5: every write strobe is followed by a pointer one higher
  p_ptr_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (ptr_q == $past(ptr_q) + 8'd1));
  // R6: reading never moves the pointer
  p_read_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD || state_q == ST_RD_ACK) |=> $stable(ptr_q));
  // R4: the line is pulled only while the bus clock is low at that moment
  p_pull_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);
  // R4: a write is taken while the slave is not driving
  p_we_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !sda_oe);
  // R7: master NACK releases the line
  p_nack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACK && scl_fall && nack_q && en && !start_ev && !stop_ev)
      |=> !sda_oe);
  // R10: held disable keeps the engine idle
  p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (state_q == ST_IDLE));

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_rs_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] strap_a,
  input  logic [1:0] strap_b,
  input  logic       alt_ctl_sel,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam int NLINES = 2;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] filt_lines;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  logic [6:0]        my_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_rs_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk  (clk),
      .rst_n(rst_int_n),
      .din  (raw_lines[g]),
      .dout (filt_lines[g])
    );
  end

  i2c_rs_busev u_ev (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .scl     (filt_lines[0]),
    .sda     (filt_lines[1]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  assign my_addr = ADDR_BASE
                 + 7'(strap_level(strap_a)) * 7'd3
                 + 7'(strap_level(strap_b));

  i2c_rs_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (~alt_ctl_sel),
    .my_addr  (my_addr),
    .scl_lvl  (filt_lines[0]),
    .sda_in   (filt_lines[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .reg_rdata(reg_rdata),
    .sda_oe   (sda_oe),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_we   (reg_we)
  );

endmodule

// File: tb/sim_i2c_reg_slave.sv
`timescale 1ns/1ps
module sim_i2c_reg_slave;
  localparam int Q = 20;
  localparam int NVEC = 5;
  // {strap_a, strap_b, pointer, data0, data1}
  localparam logic [27:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 8'h01, 8'h3C, 8'h5A},
    {2'd1, 2'd2, 8'h10, 8'hA5, 8'h00},
    {2'd2, 2'd2, 8'h7E, 8'hFF, 8'h81},
    {2'd2, 2'd1, 8'h02, 8'h69, 8'h96},
    {2'd1, 2'd0, 8'hC0, 8'h00, 8'hFE}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, reg_we, alt_sel = 1'b0, glitch_on = 1'b0;
  logic [1:0] sa = 2'd0, sb = 2'd0;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] model [256];
  logic [7:0] last_a, last_d;
  int wr_cnt = 0, drive_cnt = 0, checks = 0, fails = 0;
  bit done = 1'b0;
  wire sda_line = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  i2c_reg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_a(sa), .strap_b(sb), .alt_ctl_sel(alt_sel),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  assign reg_rdata = (reg_addr == 8'h00) ? 8'h00 : model[reg_addr];

  always @(posedge clk) begin
    if (reg_we) begin
      model[reg_addr] <= reg_wdata;
      last_a <= reg_addr;
      last_d <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (sda_oe) drive_cnt <= drive_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(Q); m_scl = 1'b1; wq(Q / 2);
    if (glitch_on) begin m_scl = 1'b0; wq(2); m_scl = 1'b1; end
    wq(Q / 2); wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); b = sda_line; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input bit m_ack, output logic [7:0] v);
    logic b;
    for (int i = 0; i < 8; i++) begin recv_bit(b); v = {v[6:0], b}; end
    send_bit(!m_ack);
  endtask

  function automatic logic [6:0] addr_of(input logic [1:0] a, input logic [1:0] b);
    int la, lb;
    la = (a == 2'd0) ? 0 : (a == 2'd1) ? 1 : 2;
    lb = (b == 2'd0) ? 0 : (b == 2'd1) ? 1 : 2;
    return 7'(8'h50 + 3 * la + lb);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rd;
    logic [6:0] ad;
    int w0, d0;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    wq(5); rst_n = 1'b1; wq(10);
    // R1: reset state
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    chk(reg_we == 1'b0 && wr_cnt == 0, "R1 no write after reset", wr_cnt, 0);

    // table walk: write burst, then pointer set + repeated START + read burst
    for (int v = 0; v < NVEC; v++) begin
      sa = VEC[v][27:26]; sb = VEC[v][25:24]; wq(4);
      ad = addr_of(sa, sb);
      w0 = wr_cnt;
      bus_start();
      send_byte({ad, 1'b0}, ack); chk(ack, "R2 address ack", ack, 1);
      send_byte(VEC[v][23:16], ack); chk(ack, "R3 command ack", ack, 1);
      send_byte(VEC[v][15:8], ack); chk(ack, "R4 data ack", ack, 1);
      chk(last_a == VEC[v][23:16] && last_d == VEC[v][15:8], "R4 write port",
          {last_a, last_d}, VEC[v][23:8]);
      send_byte(VEC[v][7:0], ack);
      chk(last_a == VEC[v][23:16] + 8'd1 && last_d == VEC[v][7:0], "R5 pointer advance",
          {last_a, last_d}, {VEC[v][23:16] + 8'd1, VEC[v][7:0]});
      bus_stop();
      chk(wr_cnt - w0 == 2, "R4 one strobe per byte", wr_cnt - w0, 2);
      bus_start();
      send_byte({ad, 1'b0}, ack);
      send_byte(VEC[v][23:16], ack);
      bus_start();
      send_byte({ad, 1'b1}, ack); chk(ack, "R8 read address after repeated START", ack, 1);
      recv_byte(1'b1, rd); chk(rd == VEC[v][15:8], "R6 first read byte", rd, VEC[v][15:8]);
      recv_byte(1'b0, rd); chk(rd == VEC[v][15:8], "R6 pointer held on read", rd, VEC[v][15:8]);
      d0 = drive_cnt; wq(Q);
      chk(drive_cnt == d0 && sda_oe == 1'b0, "R7 released after NACK", drive_cnt - d0, 0);
      bus_stop();
    end

    // R2: mismatched address ignored
    sa = 2'd1; sb = 2'd1; wq(4);
    w0 = wr_cnt;
    bus_start();
    send_byte({7'h50, 1'b0}, ack); chk(!ack, "R2 foreign address no ack", ack, 0);
    send_byte(8'h01, ack); chk(!ack, "R2 foreign command no ack", ack, 0);
    send_byte(8'h77, ack);
    bus_stop();
    chk(wr_cnt == w0, "R2 foreign transaction no write", wr_cnt - w0, 0);

    // R3: STOP after command only loads the pointer
    ad = addr_of(sa, sb);
    bus_start(); send_byte({ad, 1'b0}, ack); send_byte(8'h02, ack); send_byte(8'h44, ack); bus_stop();
    bus_start(); send_byte({ad, 1'b0}, ack); send_byte(8'h05, ack); bus_stop();
    w0 = wr_cnt;
    bus_start(); send_byte({ad, 1'b0}, ack); send_byte(8'h02, ack); bus_stop();
    chk(wr_cnt == w0, "R3 stop after command no write", wr_cnt - w0, 0);
    bus_start(); send_byte({ad, 1'b1}, ack); recv_byte(1'b0, rd); bus_stop();
    chk(rd == 8'h44, "R3 pointer stored by command", rd, 8'h44);

    // R5: wrap at the top of the pointer range
    bus_start(); send_byte({ad, 1'b0}, ack); send_byte(8'hFF, ack);
    send_byte(8'h11, ack); chk(last_a == 8'hFF, "R5 write at FF", last_a, 8'hFF);
    send_byte(8'h22, ack); chk(last_a == 8'h00, "R5 wrap to 00", last_a, 8'h00);
    bus_stop();

    // R8: repeated START after a data byte keeps the advanced pointer
    bus_start(); send_byte({ad, 1'b0}, ack); send_byte(8'h31, ack); send_byte(8'h5C, ack); bus_stop();
    bus_start(); send_byte({ad, 1'b0}, ack); send_byte(8'h30, ack); send_byte(8'h12, ack);
    bus_start(); send_byte({ad, 1'b1}, ack); recv_byte(1'b0, rd); bus_stop();
    chk(rd == 8'h5C, "R8 pointer kept across repeated START", rd, 8'h5C);

    // R9: short SCL pulses inside high phases are filtered
    w0 = wr_cnt;
    glitch_on = 1'b1;
    bus_start(); send_byte({ad, 1'b0}, ack); send_byte(8'h40, ack); send_byte(8'hC3, ack);
    glitch_on = 1'b0;
    bus_stop();
    chk(wr_cnt - w0 == 1 && last_a == 8'h40 && last_d == 8'hC3, "R9 glitch rejected",
        {last_a, last_d}, 16'h40C3);

    // R10: alternate path selected
    alt_sel = 1'b1; wq(4);
    w0 = wr_cnt; d0 = drive_cnt;
    bus_start(); send_byte({ad, 1'b0}, ack); chk(!ack, "R10 no ack when disabled", ack, 0);
    send_byte(8'h50, ack); send_byte(8'h99, ack); bus_stop();
    chk(wr_cnt == w0 && drive_cnt == d0, "R10 silent when disabled", drive_cnt - d0, 0);
    alt_sel = 1'b0; wq(4);
    bus_start(); send_byte({ad, 1'b0}, ack); bus_stop();
    chk(ack, "R10 answers again when enabled", ack, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule